// File: doc/BRIEF.md
# Charge Flush and Row Dump Sequencer

This block produces the logic-level vertical phase and drain gate controls that a full-frame CCD camera uses to empty the pixel array before an exposure, or to throw away a number of rows when only part of the image is read out. A one-cycle start command picks one of two operations. A whole-array flush raises the second vertical phase, then pulses the array-wide drain gate. A row dump performs one vertical line transfer per discarded row, with the dump-row drain gate pulsed on each transfer. After the last drain, every control stays low for a settling holdoff whose length depends on the operation. The block then raises done for one cycle.

All durations are given in system clock cycles and are captured when a start is accepted. The downstream level shifters turn the outputs into sensor clock voltages. The system integrator chooses the phase width and holdoffs so that each vertical pulse lasts at least 20 µs, the vertical rate stays at or below 25 kHz, the holdoff is at least 180 µs after a flush, and at least 20 µs after a dump. The state machine has six states. IDLE holds all outputs low. LIFT drives V1 high (dump only). PRIME drives V2 high with no drain gate. DRAIN drives V2 high with a drain gate. SETTLE holds everything low for the holdoff. FINISH raises done. The transitions are start-flush (IDLE to PRIME), start-dump (IDLE to LIFT), lift-end (LIFT to PRIME), prime-end (PRIME to DRAIN), next-row (DRAIN to LIFT while rows remain in a dump), drain-end (DRAIN to SETTLE), settle-end (SETTLE to FINISH) and release (FINISH to IDLE).

Top module: `ccd_purge_seq`

## Requirements
- R1: After reset, and whenever the block is idle, v1, v2, pfg, fdg, busy and done are all low.
- R2: A start with mode_dump = 0 (flush) gives max(phase_cyc,1) cycles of v2 high with v1 low and no drain gate. It then gives max(drain_cyc,1) cycles of v2 and pfg high. The first of these cycles follows the start edge directly.
- R3: pfg or fdg is high only in cycles where v2 is high and v1 is low.
- R4: v1 and v2 are never high in the same cycle.
- R5: After the last drain cycle, all four controls are low for max(hold,1) cycles with busy high. hold is hold_full_cyc for a flush and hold_row_cyc for a dump. done is high for exactly the next cycle, with all controls low.
- R6: A start with mode_dump = 1 (dump) performs row_count row transfers. Each transfer is max(phase_cyc,1) cycles of v1 only, then max(phase_cyc,1) cycles of v2 only, then max(drain_cyc,1) cycles of v2 and fdg. fdg never rises in a flush, pfg never rises in a dump, and the two are never high together.
- R7: A duration input of zero is treated as one cycle.
- R8: A start while busy is ignored. Changes to any setting input while busy have no effect on the running operation.
- R9: A dump start with row_count = 0 is ignored: busy stays low and the outputs stay low.
- R10: busy rises only in the cycle after an accepted start and stays high through the done cycle. In the cycle after done, busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| mode_dump | input | 1 | 0 = whole-array flush, 1 = row dump |
| phase_cyc | input | CNT_W | Width of each vertical phase pulse, cycles |
| drain_cyc | input | CNT_W | Width of each drain gate pulse, cycles |
| hold_full_cyc | input | CNT_W | Holdoff after a flush, cycles |
| hold_row_cyc | input | CNT_W | Holdoff after a dump, cycles |
| row_count | input | ROW_W | Rows to discard in a dump |
| v1 | output | 1 | Vertical phase 1 control |
| v2 | output | 1 | Vertical phase 2 control |
| pfg | output | 1 | Array-wide drain gate control |
| fdg | output | 1 | Dump-row drain gate control |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench compares every cycle of each operation with a model built from the requirements, so it catches a state that lasts one cycle too long or too short. It drives zero durations, which a design without the clamp would turn into a counter wrap of thousands of cycles. It sends a second start in the middle of an operation, with different settings. A design that re-armed or read the live inputs would change its pulse widths, holdoff or row count. It also runs dumps with one row and with several rows, to expose an off-by-one in the row count. It issues a zero-row dump, which a careless design would start or hang on. It also checks that each operation uses its own holdoff, so that a dump does not wait for the flush holdoff.

// File: rtl/purge_pkg.sv
package purge_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LIFT,
        ST_PRIME,
        ST_DRAIN,
        ST_SETTLE,
        ST_FINISH
    } purge_state_t;
endpackage

// File: rtl/purge_dwell.sv
module purge_dwell #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/purge_rows.sv
module purge_rows #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] load_val,
    input  logic             step,
    output logic             last
);
    logic [ROW_W-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left <= '0;
        else if (load)
            left <= load_val;
        else if (step && left != '0)
            left <= left - 1'b1;
    end

    assign last = (left <= 1);
endmodule

// File: rtl/ccd_purge_seq.sv
module ccd_purge_seq #(
    parameter int CNT_W = 16,
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode_dump,
    input  logic [CNT_W-1:0] phase_cyc,
    input  logic [CNT_W-1:0] drain_cyc,
    input  logic [CNT_W-1:0] hold_full_cyc,
    input  logic [CNT_W-1:0] hold_row_cyc,
    input  logic [ROW_W-1:0] row_count,
    output logic             v1,
    output logic             v2,
    output logic             pfg,
    output logic             fdg,
    output logic             busy,
    output logic             done
);
    import purge_pkg::*;

    localparam logic [CNT_W-1:0] UNIT = CNT_W'(1);

    purge_state_t     state, nxt;
    logic             dump_q;
    logic [CNT_W-1:0] phase_q, drain_q, hold_q;
    logic [CNT_W-1:0] eff_phase, eff_drain, eff_hold, dwell_val;
    logic             accept, dwell_load, dwell_done, row_step, row_last;

    function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] d);
        return (d == '0) ? '0 : d - UNIT;
    endfunction

    assign accept    = start && (!mode_dump || row_count != '0);
    assign eff_phase = (state == ST_IDLE) ? phase_cyc : phase_q;
    assign eff_drain = (state == ST_IDLE) ? drain_cyc : drain_q;
    assign eff_hold  = (state == ST_IDLE) ? (mode_dump ? hold_row_cyc : hold_full_cyc) : hold_q;

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (accept) nxt = mode_dump ? ST_LIFT : ST_PRIME;
            ST_LIFT:   if (dwell_done) nxt = ST_PRIME;
            ST_PRIME:  if (dwell_done) nxt = ST_DRAIN;
            ST_DRAIN:  if (dwell_done) nxt = (dump_q && !row_last) ? ST_LIFT : ST_SETTLE;
            ST_SETTLE: if (dwell_done) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (nxt)
            ST_LIFT, ST_PRIME: dwell_val = span(eff_phase);
            ST_DRAIN:          dwell_val = span(eff_drain);
            ST_SETTLE:         dwell_val = span(eff_hold);
            default:           dwell_val = '0;
        endcase
    end

    assign dwell_load = (nxt != state);
    assign row_step   = (state == ST_DRAIN) && dwell_done;

    // state register and settings captured at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            dump_q  <= 1'b0;
            phase_q <= '0;
            drain_q <= '0;
            hold_q  <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && accept) begin
                dump_q  <= mode_dump;
                phase_q <= phase_cyc;
                drain_q <= drain_cyc;
                hold_q  <= eff_hold;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        v1   = 1'b0;
        v2   = 1'b0;
        pfg  = 1'b0;
        fdg  = 1'b0;
        busy = 1'b1;
        done = 1'b0;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_LIFT:   v1 = 1'b1;
            ST_PRIME:  v2 = 1'b1;
            ST_DRAIN: begin
                v2  = 1'b1;
                pfg = !dump_q;
                fdg = dump_q;
            end
            ST_SETTLE: ;
            ST_FINISH: done = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    purge_dwell #(.CNT_W(CNT_W)) u_dwell (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dwell_load),
        .load_val (dwell_val),
        .expired  (dwell_done)
    );

    purge_rows #(.ROW_W(ROW_W)) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == ST_IDLE && accept),
        .load_val (row_count),
        .step     (row_step),
        .last     (row_last)
    );
endmodule

// File: rtl/purge_seq_chk.sv
module purge_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic v1,
    input logic v2,
    input logic pfg,
    input logic fdg,
    input logic busy,
    input logic done
);
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(v1 && v2));

    a_r3_drain_window: assert property (@(posedge clk) disable iff (!rst_n)
        (pfg || fdg) |-> (v2 && !v1));

    a_r6_gates_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pfg && fdg));

    a_r5_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!v1 && !v2 && !pfg && !fdg && busy));

    a_r10_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    a_r10_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r8_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!v1 && !v2 && !pfg && !fdg && !done));
endmodule

bind ccd_purge_seq purge_seq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .v1    (v1),
    .v2    (v2),
    .pfg   (pfg),
    .fdg   (fdg),
    .busy  (busy),
    .done  (done)
);

// File: tb/sim_ccd_purge_seq.sv
module sim_ccd_purge_seq;
    localparam int CNT_W = 16;
    localparam int ROW_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             mode_dump = 1'b0;
    logic [CNT_W-1:0] phase_cyc = '0, drain_cyc = '0, hold_full_cyc = '0, hold_row_cyc = '0;
    logic [ROW_W-1:0] row_count = '0;
    logic             v1, v2, pfg, fdg, busy, done;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ccd_purge_seq #(.CNT_W(CNT_W), .ROW_W(ROW_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_dump(mode_dump),
        .phase_cyc(phase_cyc), .drain_cyc(drain_cyc),
        .hold_full_cyc(hold_full_cyc), .hold_row_cyc(hold_row_cyc),
        .row_count(row_count),
        .v1(v1), .v2(v2), .pfg(pfg), .fdg(fdg), .busy(busy), .done(done)
    );

    function automatic int clampd(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    function automatic int op_len(input bit dm, input int p, input int d, input int h, input int n);
        int lp = clampd(p), ld = clampd(d), lh = clampd(h);
        if (dm) return n * (2 * lp + ld) + lh + 1;
        return lp + ld + lh + 1;
    endfunction

    // expected {v1,v2,pfg,fdg,busy,done} for cycle k after the start edge
    function automatic logic [5:0] expect_vec(input bit dm, input int p, input int d,
                                              input int h, input int n, input int k);
        int lp = clampd(p), ld = clampd(d), lh = clampd(h);
        int body;
        if (dm) begin
            int row = 2 * lp + ld;
            body = n * row;
            if (k < body) begin
                int r = k % row;
                if (r < lp) return 6'b100010;
                if (r < 2 * lp) return 6'b010010;
                return 6'b010110;
            end
        end else begin
            body = lp + ld;
            if (k < lp) return 6'b010010;
            if (k < body) return 6'b011010;
        end
        if (k < body + lh) return 6'b000010;
        if (k == body + lh) return 6'b000011;
        return 6'b000000;
    endfunction

    task automatic check(input bit ok, input string req, input logic [5:0] act, input logic [5:0] exp_v, input int k);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %b expected %b", req, k, act, exp_v);
        end
    endtask

    // one operation; poke = issue a second start with other settings mid-run (R8)
    task automatic run_op(input bit dm, input int p, input int d, input int hf, input int hr,
                          input int n, input bit poke, input string req);
        int h = dm ? hr : hf;
        int total = op_len(dm, p, d, h, n);
        bit bad = 0;
        logic [5:0] first_act = '0, first_exp = '0;
        int first_k = 0;
        @(negedge clk);
        mode_dump = dm; phase_cyc = CNT_W'(p); drain_cyc = CNT_W'(d);
        hold_full_cyc = CNT_W'(hf); hold_row_cyc = CNT_W'(hr); row_count = ROW_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= total; k++) begin
            logic [5:0] act = {v1, v2, pfg, fdg, busy, done};
            logic [5:0] ev  = expect_vec(dm, p, d, h, n, k);
            if (act !== ev && !bad) begin
                bad = 1; first_act = act; first_exp = ev; first_k = k;
            end
            if (poke && k == 1) begin
                start = 1'b1; mode_dump = ~dm; phase_cyc = 16'd9; drain_cyc = 16'd7;
                hold_full_cyc = 16'd11; hold_row_cyc = 16'd13; row_count = 8'd5;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        check(!bad, req, first_act, first_exp, first_k);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({v1, v2, pfg, fdg, busy, done} === 6'b0, "R1 reset",
              {v1, v2, pfg, fdg, busy, done}, 6'b0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({v1, v2, pfg, fdg, busy, done} === 6'b0, "R1 idle",
              {v1, v2, pfg, fdg, busy, done}, 6'b0, 0);

        run_op(0, 3, 2, 5, 1, 1, 0, "R2 R5 flush");
        run_op(1, 2, 2, 9, 3, 3, 0, "R6 R5 three-row dump");
        run_op(1, 4, 1, 2, 6, 1, 0, "R6 one-row dump");
        run_op(0, 0, 0, 0, 0, 1, 0, "R7 zero durations flush");
        run_op(1, 0, 0, 0, 0, 2, 0, "R7 zero durations dump");
        run_op(0, 2, 3, 4, 1, 1, 1, "R8 start while busy flush");
        run_op(1, 1, 2, 1, 3, 2, 1, "R8 start while busy dump");

        // R9: zero-row dump is ignored
        @(negedge clk);
        mode_dump = 1'b1; row_count = '0; phase_cyc = 16'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check({v1, v2, pfg, fdg, busy, done} === 6'b0, "R9 zero-row dump",
                  {v1, v2, pfg, fdg, busy, done}, 6'b0, k);
            @(negedge clk);
        end

        // R10 and R2/R6: constrained random mix
        void'($urandom(32'd4711));
        for (int i = 0; i < 16; i++) begin
            bit dm = 1'($urandom % 2);
            run_op(dm, int'($urandom % 6), int'($urandom % 5), int'($urandom % 8),
                   int'($urandom % 8), 1 + int'($urandom % 4), 1'($urandom % 3 == 0),
                   dm ? "R6 R10 random dump" : "R2 R10 random flush");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule